// File: doc/BRIEF.md
# Two-Inlet Input-Queued Switching Element with Selectable Flow Control

This block is one 2x2 cell switching element. Each of its two inlets writes into a private FIFO that holds `DEPTH` cells. In every slot (one clock cycle), the element looks at the oldest cell of each FIFO. The most significant bit of that cell chooses its outlet. A round-robin picker for each outlet then chooses which cell goes out. A chosen cell leaves its FIFO at the end of the slot and appears on its outlet in the next cycle, unchanged.

The element receives a free-space count for each outlet from the downstream neighbour. It sends its own per-inlet free-space count upstream on separate wires; these are never shared with the cell path. A run-time mode input selects how the element treats a downstream neighbour with no room:

- In hold mode, an outlet whose downstream count is zero sends nothing, and the waiting cell keeps its place at the front of its FIFO.
- In loss mode, cells go out regardless of the downstream count, and the receiver is left to discard what it cannot store.

Top module: `sw2_iq_elem`

## Requirements
- R1: After reset, both FIFOs are empty, each `free_o` entry equals `DEPTH`, and `out_valid_o` and `drop_o` are all zero.
- R2: A cell whose bit `CELL_W-1` is 0 targets outlet 0, and a cell whose bit `CELL_W-1` is 1 targets outlet 1. A cell granted in slot t is shown on `out_cell_o` of its outlet, with `out_valid_o` high, in the cycle after the edge that ends slot t. The cell's bits are unchanged.
- R3: Each FIFO hands out cells in arrival order, stores at most `DEPTH` cells, and performs at most one read and one write per slot.
- R4: `free_o[i]` equals `DEPTH` minus the occupancy of FIFO i. It is a register output, updated at each edge, and it already reflects both the read and the write of the slot just ended.
- R5: When both front cells target the same eligible outlet, that outlet's pointer picks the winner. After reset the pointer favours inlet 0. After any grant on that outlet, the pointer favours the other inlet.
- R6: With `mode_loss_i` = 0 (hold mode), an outlet whose `ds_free_i` is 0 sends nothing in that slot, and the blocked cell stays at the front of its FIFO.
- R7: With `mode_loss_i` = 1 (loss mode), an outlet sends whenever a front cell targets it, whatever the value of `ds_free_i`. The mode may change in any slot and takes effect in that slot.
- R8: An arriving cell is discarded when its FIFO is full and no read happens on that FIFO in the same slot. `drop_o[i]` is then high for one cycle after that edge. If a read does happen in that slot, the cell is accepted.
- R9: A cell waiting behind a blocked front cell does not go out, even when its own outlet is free (head-of-line blocking).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_loss_i | input | 1 | 0 = hold (backpressure) mode, 1 = loss mode |
| in_valid_i | input | 2 | Cell present on inlet i |
| in_cell_i | input | 2 x CELL_W | Cell on inlet i; MSB is the route tag |
| free_o | output | 2 x CNT_W | Free slots in FIFO i, sent upstream |
| ds_free_i | input | 2 x CNT_W | Free slots reported downstream for outlet o |
| out_valid_o | output | 2 | Cell present on outlet o |
| out_cell_o | output | 2 x CELL_W | Cell on outlet o |
| drop_o | output | 2 | Arriving cell on inlet i was discarded |

## Verification
The hardest state to reach from the ports is a FIFO that is full at the moment a read and an arrival coincide. In hold mode a well-behaved upstream never offers a cell into zero free space, so this state only comes from deliberate stimulus. The bench first blocks an outlet in hold mode to fill one FIFO. It then offers one more cell, which must be dropped. Next it opens the outlet in the same slot as another arrival, which must be accepted. A long pseudo-random sweep alternates the modes and often presents zero downstream space, so contention, pointer turnover and head-of-line blocking all recur under a cycle-exact arithmetic model.

// File: rtl/sw2_pkg.sv
package sw2_pkg;
    typedef enum logic {
        XFER_HOLD = 1'b0,
        XFER_LOSS = 1'b1
    } xfer_mode_e;

    localparam int NUM_PORTS = 2;
endpackage

// File: rtl/sw2_cell_queue.sv
module sw2_cell_queue #(
    parameter int DEPTH  = 4,
    parameter int CELL_W = 8,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [CELL_W-1:0] cell_i,
    input  logic              pop_i,
    output logic [CELL_W-1:0] head_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              drop_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
        logic             drop;
    } q_state_t;

    q_state_t s_d, s_q;
    logic [CELL_W-1:0] mem_q [DEPTH];
    logic do_pop, do_push;

    always_comb begin
        s_d     = s_q;
        do_pop  = pop_i && (s_q.cnt != '0);
        do_push = push_i && ((s_q.cnt != FULL) || do_pop);
        s_d.drop = push_i && !do_push;
        if (do_pop)  s_d.rd = (s_q.rd == LAST) ? '0 : s_q.rd + 1'b1;
        if (do_push) s_d.wr = (s_q.wr == LAST) ? '0 : s_q.wr + 1'b1;
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[s_q.wr] <= cell_i;
    end

    assign head_o  = mem_q[s_q.rd];
    assign count_o = s_q.cnt;
    assign drop_o  = s_q.drop;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= FULL);
    assert_pop_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (s_q.cnt != '0));
    assert_count_grows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && s_q.cnt != FULL) |=> (s_q.cnt == $past(s_q.cnt) + 1'b1));
endmodule

// File: rtl/sw2_rr_pick.sv
module sw2_rr_pick (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req_i,
    input  logic       en_i,
    output logic [1:0] grant_o
);
    typedef struct packed {
        logic favour;
    } rr_state_t;

    rr_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        grant_o = '0;
        if (en_i) begin
            if (req_i == 2'b11) grant_o[s_q.favour] = 1'b1;
            else                grant_o = req_i;
        end
        if (grant_o[0]) s_d.favour = 1'b1;
        if (grant_o[1]) s_d.favour = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_single_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));
    assert_turn_taking_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == 2'b11 && en_i && $past(req_i == 2'b11 && en_i && grant_o[0])) |-> grant_o[1]);
    assert_grant_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_o & ~req_i) == 2'b00));
endmodule

// File: rtl/sw2_iq_elem.sv
module sw2_iq_elem #(
    parameter int DEPTH  = 4,
    parameter int CELL_W = 8,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mode_loss_i,
    input  logic [1:0]             in_valid_i,
    input  logic [1:0][CELL_W-1:0] in_cell_i,
    output logic [1:0][CNT_W-1:0]  free_o,
    input  logic [1:0][CNT_W-1:0]  ds_free_i,
    output logic [1:0]             out_valid_o,
    output logic [1:0][CELL_W-1:0] out_cell_o,
    output logic [1:0]             drop_o
);
    import sw2_pkg::*;

    localparam int TAG_BIT = CELL_W - 1;

    typedef struct packed {
        logic [1:0]             ov;
        logic [1:0][CELL_W-1:0] oc;
    } out_state_t;

    out_state_t s_d, s_q;
    xfer_mode_e mode;

    logic [CELL_W-1:0] head  [NUM_PORTS];
    logic [CNT_W-1:0]  cnt   [NUM_PORTS];
    logic [1:0]        req   [NUM_PORTS];
    logic [1:0]        grant [NUM_PORTS];
    logic [1:0]        en;
    logic [1:0]        pop;

    assign mode = xfer_mode_e'(mode_loss_i);

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_inlet
        sw2_cell_queue #(.DEPTH(DEPTH), .CELL_W(CELL_W), .CNT_W(CNT_W)) i_queue (
            .clk     (clk),
            .rst_n   (rst_n),
            .push_i  (in_valid_i[i]),
            .cell_i  (in_cell_i[i]),
            .pop_i   (pop[i]),
            .head_o  (head[i]),
            .count_o (cnt[i]),
            .drop_o  (drop_o[i])
        );
        assign free_o[i] = CNT_W'(DEPTH) - cnt[i];
        assign pop[i]    = grant[0][i] | grant[1][i];
    end

    for (genvar o = 0; o < NUM_PORTS; o++) begin : g_outlet
        always_comb begin
            for (int i = 0; i < NUM_PORTS; i++)
                req[o][i] = (cnt[i] != '0) && (head[i][TAG_BIT] == 1'(o));
            en[o] = (mode == XFER_LOSS) || (ds_free_i[o] != '0);
        end
        sw2_rr_pick i_pick (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_i   (req[o]),
            .en_i    (en[o]),
            .grant_o (grant[o])
        );
    end

    always_comb begin
        s_d = s_q;
        for (int o = 0; o < NUM_PORTS; o++) begin
            s_d.ov[o] = |grant[o];
            s_d.oc[o] = grant[o][1] ? head[1] : head[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid_o = s_q.ov;
    assign out_cell_o  = s_q.oc;

    for (genvar o = 0; o < NUM_PORTS; o++) begin : g_chk
        assert_hold_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode_loss_i && ds_free_i[o] == '0) |=> !out_valid_o[o]);
        assert_tag_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid_o[o] |-> (out_cell_o[o][TAG_BIT] == 1'(o)));
        assert_drop_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
            drop_o[o] |-> ($past(free_o[o]) == '0));
    end
endmodule

// File: tb/test_sw2_iq_elem.sv
`timescale 1ns/1ps
module test_sw2_iq_elem;
    localparam int DEPTH = 4;
    localparam int CW    = 8;
    localparam int NW    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode = 1'b0;
    logic [1:0] in_v = '0;
    logic [1:0][CW-1:0] in_c = '0;
    logic [1:0][NW-1:0] free_o;
    logic [1:0][NW-1:0] ds_f = '0;
    logic [1:0] out_v;
    logic [1:0][CW-1:0] out_c;
    logic [1:0] drop;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [CW-1:0] mq [2][DEPTH];
    int mcnt [2];
    int mptr [2];

    always #10 clk = ~clk;

    sw2_iq_elem #(.DEPTH(DEPTH), .CELL_W(CW)) i_sw2_iq_elem (
        .clk(clk), .rst_n(rst_n), .mode_loss_i(mode), .in_valid_i(in_v),
        .in_cell_i(in_c), .free_o(free_o), .ds_free_i(ds_f),
        .out_valid_o(out_v), .out_cell_o(out_c), .drop_o(drop)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic slot(input string tag, input logic md, input logic v0, input logic [CW-1:0] c0,
                        input logic v1, input logic [CW-1:0] c1, input int f0, input int f1);
        logic [1:0] ev, ed, pp, vin;
        logic [CW-1:0] ec [2];
        logic [CW-1:0] cin [2];
        int fin [2];
        logic r0, r1, acc;
        int win;
        mode = md; in_v = {v1, v0}; in_c[0] = c0; in_c[1] = c1;
        ds_f[0] = NW'(f0); ds_f[1] = NW'(f1);
        vin = {v1, v0}; cin[0] = c0; cin[1] = c1; fin[0] = f0; fin[1] = f1;
        ev = '0; ed = '0; pp = '0; ec[0] = '0; ec[1] = '0;
        for (int o = 0; o < 2; o++) begin
            r0 = (mcnt[0] > 0) && (int'(mq[0][0][CW-1]) == o);
            r1 = (mcnt[1] > 0) && (int'(mq[1][0][CW-1]) == o);
            win = -1;
            if (md || fin[o] != 0) begin
                if (r0 && r1) win = mptr[o];
                else if (r0)  win = 0;
                else if (r1)  win = 1;
            end
            if (win >= 0) begin
                ev[o] = 1'b1; ec[o] = mq[win][0]; pp[win] = 1'b1; mptr[o] = 1 - win;
            end
        end
        for (int i = 0; i < 2; i++) begin
            acc = vin[i] && ((mcnt[i] < DEPTH) || pp[i]);
            ed[i] = vin[i] && !acc;
            if (pp[i]) begin
                for (int k = 0; k < DEPTH - 1; k++) mq[i][k] = mq[i][k+1];
                mcnt[i]--;
            end
            if (acc) begin
                mq[i][mcnt[i]] = cin[i];
                mcnt[i]++;
            end
        end
        @(posedge clk); #1;
        for (int o = 0; o < 2; o++) begin
            chk({tag, " R2 R5 R6 R7 R9 out_valid"}, int'(out_v[o]), int'(ev[o]));
            if (ev[o]) chk({tag, " R2 R3 out_cell"}, int'(out_c[o]), int'(ec[o]));
            chk({tag, " R4 free"}, int'(free_o[o]), DEPTH - mcnt[o]);
            chk({tag, " R8 drop"}, int'(drop[o]), int'(ed[o]));
        end
    endtask

    task automatic drain();
        for (int n = 0; n < 20 && (mcnt[0] + mcnt[1]) > 0; n++)
            slot("drain", 1'b1, 1'b0, '0, 1'b0, '0, 4, 4);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        mcnt[0] = 0; mcnt[1] = 0; mptr[0] = 0; mptr[1] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        for (int i = 0; i < 2; i++) begin
            chk("R1 free after reset", int'(free_o[i]), DEPTH);
            chk("R1 out_valid after reset", int'(out_v[i]), 0);
            chk("R1 drop after reset", int'(drop[i]), 0);
        end
        // R2 routing by tag bit
        slot("R2", 1'b0, 1'b1, 8'h05, 1'b1, 8'h8A, 4, 4);
        slot("R2", 1'b0, 1'b1, 8'h91, 1'b1, 8'h12, 4, 4);
        slot("R2", 1'b0, 1'b0, '0, 1'b0, '0, 4, 4);
        slot("R2", 1'b0, 1'b0, '0, 1'b0, '0, 4, 4);
        // R5 contention on outlet 0, alternating winners
        for (int n = 0; n < 4; n++)
            slot("R5", 1'b0, 1'b1, 8'(8'h20 + n), 1'b1, 8'(8'h40 + n), 4, 4);
        drain();
        // R6 hold mode blocks; R7 loss mode ignores downstream space
        slot("R6", 1'b0, 1'b1, 8'h33, 1'b0, '0, 0, 4);
        slot("R6", 1'b0, 1'b0, '0, 1'b0, '0, 0, 4);
        slot("R6", 1'b0, 1'b0, '0, 1'b0, '0, 0, 4);
        slot("R7", 1'b1, 1'b0, '0, 1'b1, 8'hC4, 0, 0);
        slot("R7", 1'b1, 1'b0, '0, 1'b0, '0, 0, 0);
        drain();
        // R8 fill inlet 0, overflow drops, simultaneous read accepts
        for (int n = 0; n < DEPTH; n++)
            slot("R8", 1'b0, 1'b1, 8'(8'h01 + n), 1'b0, '0, 0, 0);
        slot("R8", 1'b0, 1'b1, 8'h0E, 1'b0, '0, 0, 0);
        slot("R8", 1'b0, 1'b1, 8'h0F, 1'b0, '0, 1, 0);
        slot("R8", 1'b0, 1'b0, '0, 1'b0, '0, 0, 0);
        drain();
        // R9 head-of-line blocking
        slot("R9", 1'b0, 1'b1, 8'h07, 1'b0, '0, 0, 4);
        slot("R9", 1'b0, 1'b1, 8'h87, 1'b0, '0, 0, 4);
        for (int n = 0; n < 3; n++)
            slot("R9", 1'b0, 1'b0, '0, 1'b0, '0, 0, 4);
        slot("R9", 1'b0, 1'b0, '0, 1'b0, '0, 1, 4);
        slot("R9", 1'b0, 1'b0, '0, 1'b0, '0, 1, 4);
        drain();
        // R3 R4 pseudo-random sweep, both modes
        lf = 32'hACE1_2345;
        for (int n = 0; n < 4000; n++) begin
            logic md, a0, a1;
            int f0, f1;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            md = ((n / 500) % 2) == 1;
            a0 = lf[0] && (md || mcnt[0] < DEPTH);
            a1 = lf[1] && (md || mcnt[1] < DEPTH);
            f0 = (lf[5:4] == 2'b00) ? 0 : int'(lf[7:6]) + 1;
            f1 = (lf[9:8] == 2'b00) ? 0 : int'(lf[11:10]) + 1;
            slot("R3 R4 sweep", md, a0, lf[19:12], a1, lf[27:20], f0, f1);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule